// File: doc/BRIEF.md
# Prefix-extended byte instruction sequencer

This block is the fetch-and-execute core of a small stack machine. It fetches one instruction byte at a time from a byte-addressed fetch port. Each byte holds a function code and a 4-bit data value. Prefix bytes build operands wider than four bits in an operand register, four bits per byte, and can also produce negative values. All other bytes use the accumulated operand and then clear the register.

Architectural state is a three-entry evaluation stack (A on top, then B, then C), a workspace pointer and an instruction pointer. Loads and stores of local and non-local words go through a 32-bit word data port. Operate-group codes are handed to a separate unit over a request/done strobe. All three outward ports are request/acknowledge handshakes:
- Once a request is raised, the block holds the request and every address and data field it drives, unchanged, until the acknowledge is sampled high on a rising edge.
- The responder may stall for any number of cycles.
- Only one of the three requests is ever active at a time.

Top module: `pfx_seq`

## Requirements
- R1: After reset, A, B and C are 0, the workspace pointer equals RST_WPTR, the instruction pointer equals RST_IPTR, and the block requests a fetch at RST_IPTR.
- R2: A byte's bits 7:4 select the function and bits 3:0 are its data nibble. The function codes are:
  - 0: jump
  - 1: load local pointer
  - 2: positive prefix
  - 3: load non-local
  - 4: load constant
  - 5: load non-local pointer
  - 6: negative prefix
  - 7: load local
  - B: adjust workspace
  - C: equal-to-constant
  - D: store local
  - E: store non-local
  - F: operate
  - 8, 9 and A are reserved. They only clear the operand register and advance the instruction pointer.
- R3: A positive prefix sets the operand register to (register OR nibble) shifted left by 4. A negative prefix sets it to the complement of (register OR nibble), shifted left by 4. Neither prefix touches the stack.
- R4: Every non-prefix byte uses (operand register OR zero-extended nibble) as its operand and leaves the operand register at zero.
- R5: Load constant pushes the operand, load local pointer pushes workspace + 4*operand, and load local pushes the word read from workspace + 4*operand. A push moves B to C, moves A to B, and puts the new value in A.
- R6: Store local writes A to workspace + 4*operand. It then moves B to A and C to B, and C keeps its value.
- R7: Load non-local replaces A with the word at A + 4*operand. Load non-local pointer adds 4*operand to A. Store non-local writes B to A + 4*operand and then copies C into A.
- R8: Adjust workspace adds 4*operand to the workspace pointer. Equal-to-constant sets A to 1 when A equals the operand and to 0 otherwise.
- R9: A jump loads the instruction pointer with (address of the jump byte) + 1 + operand. Every other byte advances the pointer by 1.
- R10: if_req stays high with a stable if_addr until if_ack. Exactly one byte is consumed per acknowledged fetch.
- R11: A data access holds dm_req, dm_we, dm_addr and dm_wdata stable until dm_ack, and no fetch starts until it completes. Words are little-endian: bits 7:0 belong to the byte at dm_addr.
- R12: An operate byte raises op_valid, with op_code equal to the operand, until op_done. The stack stays unchanged throughout, and fetching resumes afterwards.
- R13: At most one of if_req, dm_req and op_valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req | output | 1 | Instruction byte fetch request |
| if_addr | output | WORD_W | Byte address of the fetch |
| if_ack | input | 1 | Fetch completes; if_byte valid |
| if_byte | input | 8 | Fetched instruction byte |
| dm_req | output | 1 | Data word access request |
| dm_we | output | 1 | 1 = write, 0 = read |
| dm_addr | output | WORD_W | Byte address of the word |
| dm_wdata | output | WORD_W | Store data |
| dm_ack | input | 1 | Access completes; dm_rdata valid for reads |
| dm_rdata | input | WORD_W | Load data |
| op_valid | output | 1 | Operate code offered |
| op_code | output | WORD_W | Full operand of the operate byte |
| op_done | input | 1 | Operate unit finished |
| stk_a | output | WORD_W | Stack entry A |
| stk_b | output | WORD_W | Stack entry B |
| stk_c | output | WORD_W | Stack entry C |
| wptr | output | WORD_W | Workspace pointer |
| iptr | output | WORD_W | Instruction pointer |

## Verification
The assertions check on every cycle the properties that hold whatever the program is:
- the three handshakes stay stable under back-pressure, and only one request is ever active;
- the stack stays frozen while an operate code is outstanding;
- a positive prefix steps the operand register and the instruction pointer as required;
- every jump lands on the computed target.

Arithmetic results can only be shown by running byte programs against the bench's reference model under randomized acknowledge delays. These include:
- negative prefix chains;
- operand clearing after reserved codes;
- the pop order of the two stores;
- workspace adjustment by negative amounts;
- loads that read back earlier stores.

// File: rtl/pfx_seq_pkg.sv
package pfx_seq_pkg;

  // Function codes carried in bits 7:4 of an instruction byte
  typedef enum logic [3:0] {
    FN_JUMP  = 4'h0,
    FN_LDLP  = 4'h1,
    FN_PFIX  = 4'h2,
    FN_LDNL  = 4'h3,
    FN_LDC   = 4'h4,
    FN_LDNLP = 4'h5,
    FN_NFIX  = 4'h6,
    FN_LDL   = 4'h7,
    FN_RSV8  = 4'h8,
    FN_RSV9  = 4'h9,
    FN_RSVA  = 4'hA,
    FN_AJW   = 4'hB,
    FN_EQC   = 4'hC,
    FN_STL   = 4'hD,
    FN_STNL  = 4'hE,
    FN_OPER  = 4'hF
  } fn_e;

  typedef enum logic [1:0] {PH_FETCH, PH_MEM, PH_OPER} phase_e;

  typedef enum logic [1:0] {MK_LDL, MK_LDNL, MK_STL, MK_STNL} memk_e;

  typedef enum logic [2:0] {SK_HOLD, SK_PUSH, SK_LOAD_A, SK_POP, SK_A_FROM_C} stk_op_e;

  typedef enum logic [1:0] {OR_HOLD, OR_POS, OR_NEG, OR_CLR} or_op_e;

endpackage

// File: rtl/pfx_seq_operand.sv
module pfx_seq_operand
  import pfx_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  or_op_e            op,
  input  logic [NIB_W-1:0]  nib,
  output logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] oreg
);

  logic [WORD_W-1:0] merged;

  assign merged = oreg | {{(WORD_W-NIB_W){1'b0}}, nib};
  assign opnd   = merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oreg <= '0;
    end else begin
      case (op)
        OR_POS:  oreg <= merged << NIB_W;
        OR_NEG:  oreg <= (~merged) << NIB_W;
        OR_CLR:  oreg <= '0;
        default: oreg <= oreg;
      endcase
    end
  end

endmodule

// File: rtl/pfx_seq_stack.sv
module pfx_seq_stack
  import pfx_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] a,
  output logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] c
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a <= '0;
      b <= '0;
      c <= '0;
    end else begin
      case (op)
        SK_PUSH: begin
          c <= b;
          b <= a;
          a <= din;
        end
        SK_LOAD_A:   a <= din;
        SK_POP: begin
          a <= b;
          b <= c;
        end
        SK_A_FROM_C: a <= c;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
  import pfx_seq_pkg::*;
#(
  parameter int              WORD_W   = 32,
  parameter logic [WORD_W-1:0] RST_IPTR = '0,
  parameter logic [WORD_W-1:0] RST_WPTR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              if_req,
  output logic [WORD_W-1:0] if_addr,
  input  logic              if_ack,
  input  logic [7:0]        if_byte,
  output logic              dm_req,
  output logic              dm_we,
  output logic [WORD_W-1:0] dm_addr,
  output logic [WORD_W-1:0] dm_wdata,
  input  logic              dm_ack,
  input  logic [WORD_W-1:0] dm_rdata,
  output logic              op_valid,
  output logic [WORD_W-1:0] op_code,
  input  logic              op_done,
  output logic [WORD_W-1:0] stk_a,
  output logic [WORD_W-1:0] stk_b,
  output logic [WORD_W-1:0] stk_c,
  output logic [WORD_W-1:0] wptr,
  output logic [WORD_W-1:0] iptr
);

  localparam int NIB_W = 4;
  localparam int WSH   = $clog2(WORD_W / 8);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  phase_e            phase_q, phase_d;
  memk_e             memk_q, memk_d;
  logic [WORD_W-1:0] maddr_q, maddr_d;
  logic [WORD_W-1:0] opcode_q, opcode_d;
  logic [WORD_W-1:0] iptr_q, iptr_d;
  logic [WORD_W-1:0] wptr_q, wptr_d;

  or_op_e            or_op;
  stk_op_e           stk_op;
  logic [WORD_W-1:0] stk_din;
  logic [WORD_W-1:0] opnd, opnd_sc, oreg_q;
  logic [NIB_W-1:0]  nib;
  logic [3:0]        fn;

  assign fn      = if_byte[7:4];
  assign nib     = if_byte[NIB_W-1:0];
  assign opnd_sc = opnd << WSH;

  pfx_seq_operand #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_operand (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (or_op),
    .nib  (nib),
    .opnd (opnd),
    .oreg (oreg_q)
  );

  pfx_seq_stack #(.WORD_W(WORD_W)) u_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (stk_op),
    .din  (stk_din),
    .a    (stk_a),
    .b    (stk_b),
    .c    (stk_c)
  );

  // Decode and sequencing
  always_comb begin
    phase_d  = phase_q;
    memk_d   = memk_q;
    maddr_d  = maddr_q;
    opcode_d = opcode_q;
    iptr_d   = iptr_q;
    wptr_d   = wptr_q;
    or_op    = OR_HOLD;
    stk_op   = SK_HOLD;
    stk_din  = '0;
    case (phase_q)
      PH_FETCH: begin
        if (if_ack) begin
          iptr_d = iptr_q + ONE;
          or_op  = OR_CLR;
          case (fn)
            FN_PFIX: or_op = OR_POS;
            FN_NFIX: or_op = OR_NEG;
            FN_JUMP: iptr_d = iptr_q + ONE + opnd;
            FN_LDC: begin
              stk_op  = SK_PUSH;
              stk_din = opnd;
            end
            FN_LDLP: begin
              stk_op  = SK_PUSH;
              stk_din = wptr_q + opnd_sc;
            end
            FN_LDNLP: begin
              stk_op  = SK_LOAD_A;
              stk_din = stk_a + opnd_sc;
            end
            FN_EQC: begin
              stk_op  = SK_LOAD_A;
              stk_din = {{(WORD_W-1){1'b0}}, (stk_a == opnd)};
            end
            FN_AJW: wptr_d = wptr_q + opnd_sc;
            FN_LDL: begin
              phase_d = PH_MEM;
              memk_d  = MK_LDL;
              maddr_d = wptr_q + opnd_sc;
            end
            FN_STL: begin
              phase_d = PH_MEM;
              memk_d  = MK_STL;
              maddr_d = wptr_q + opnd_sc;
            end
            FN_LDNL: begin
              phase_d = PH_MEM;
              memk_d  = MK_LDNL;
              maddr_d = stk_a + opnd_sc;
            end
            FN_STNL: begin
              phase_d = PH_MEM;
              memk_d  = MK_STNL;
              maddr_d = stk_a + opnd_sc;
            end
            FN_OPER: begin
              phase_d  = PH_OPER;
              opcode_d = opnd;
            end
            default: ;
          endcase
        end
      end
      PH_MEM: begin
        if (dm_ack) begin
          phase_d = PH_FETCH;
          case (memk_q)
            MK_LDL: begin
              stk_op  = SK_PUSH;
              stk_din = dm_rdata;
            end
            MK_LDNL: begin
              stk_op  = SK_LOAD_A;
              stk_din = dm_rdata;
            end
            MK_STL:  stk_op = SK_POP;
            default: stk_op = SK_A_FROM_C;
          endcase
        end
      end
      default: begin
        if (op_done) phase_d = PH_FETCH;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_FETCH;
      memk_q   <= MK_LDL;
      maddr_q  <= '0;
      opcode_q <= '0;
      iptr_q   <= RST_IPTR;
      wptr_q   <= RST_WPTR;
    end else begin
      phase_q  <= phase_d;
      memk_q   <= memk_d;
      maddr_q  <= maddr_d;
      opcode_q <= opcode_d;
      iptr_q   <= iptr_d;
      wptr_q   <= wptr_d;
    end
  end

  assign if_req   = (phase_q == PH_FETCH);
  assign if_addr  = iptr_q;
  assign dm_req   = (phase_q == PH_MEM);
  assign dm_we    = dm_req && ((memk_q == MK_STL) || (memk_q == MK_STNL));
  assign dm_addr  = maddr_q;
  assign dm_wdata = (memk_q == MK_STL) ? stk_a : stk_b;
  assign op_valid = (phase_q == PH_OPER);
  assign op_code  = opcode_q;
  assign iptr     = iptr_q;
  assign wptr     = wptr_q;

endmodule

// File: rtl/pfx_seq_chk.sv
module pfx_seq_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              if_req,
  input logic [WORD_W-1:0] if_addr,
  input logic              if_ack,
  input logic [7:0]        if_byte,
  input logic              dm_req,
  input logic              dm_we,
  input logic [WORD_W-1:0] dm_addr,
  input logic [WORD_W-1:0] dm_wdata,
  input logic              dm_ack,
  input logic              op_valid,
  input logic [WORD_W-1:0] op_code,
  input logic              op_done,
  input logic [WORD_W-1:0] stk_a,
  input logic [WORD_W-1:0] stk_b,
  input logic [WORD_W-1:0] stk_c,
  input logic [WORD_W-1:0] iptr,
  input logic [WORD_W-1:0] oreg
);

  logic [WORD_W-1:0] nibx, jmp_tgt, pfx_next;
  logic              fire_jump, fire_pfix;

  assign nibx      = {{(WORD_W-4){1'b0}}, if_byte[3:0]};
  assign jmp_tgt   = iptr + WORD_W'(1) + (oreg | nibx);
  assign pfx_next  = (oreg | nibx) << 4;
  assign fire_jump = if_req && if_ack && (if_byte[7:4] == 4'h0);
  assign fire_pfix = if_req && if_ack && (if_byte[7:4] == 4'h2);

  // R10
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && !if_ack) |=> (if_req && $stable(if_addr)));

  // R11
  dmem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req && !dm_ack) |=> (dm_req && $stable(dm_we) && $stable(dm_addr) && $stable(dm_wdata)));

  // R12
  oper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_done) |=> (op_valid && $stable(op_code)));

  // R12
  oper_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ($stable(stk_a) && $stable(stk_b) && $stable(stk_c)));

  // R13
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({if_req, dm_req, op_valid}));

  // R3
  prefix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_pfix |=> ((oreg == $past(pfx_next)) && (iptr == $past(iptr) + WORD_W'(1))
                   && $stable(stk_a) && $stable(stk_b) && $stable(stk_c)));

  // R9
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_jump |=> ((iptr == $past(jmp_tgt)) && (oreg == '0)));

endmodule

bind pfx_seq pfx_seq_chk #(.WORD_W(WORD_W)) u_pfx_seq_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .if_req  (if_req),
  .if_addr (if_addr),
  .if_ack  (if_ack),
  .if_byte (if_byte),
  .dm_req  (dm_req),
  .dm_we   (dm_we),
  .dm_addr (dm_addr),
  .dm_wdata(dm_wdata),
  .dm_ack  (dm_ack),
  .op_valid(op_valid),
  .op_code (op_code),
  .op_done (op_done),
  .stk_a   (stk_a),
  .stk_b   (stk_b),
  .stk_c   (stk_c),
  .iptr    (iptr),
  .oreg    (oreg_q)
);

// File: tb/test_pfx_seq.sv
`timescale 1ns/1ps
module test_pfx_seq;

  localparam int W = 32;
  localparam logic [31:0] WP0 = 32'h0000_1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        if_req, if_ack = 1'b0;
  logic [31:0] if_addr;
  logic [7:0]  if_byte = 8'h00;
  logic        dm_req, dm_we, dm_ack = 1'b0;
  logic [31:0] dm_addr, dm_wdata, dm_rdata = '0;
  logic        op_valid, op_done = 1'b0;
  logic [31:0] op_code;
  logic [31:0] stk_a, stk_b, stk_c, wptr, iptr;

  pfx_seq #(.WORD_W(W), .RST_IPTR(32'h0), .RST_WPTR(WP0)) i_pfx_seq (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_ack(if_ack), .if_byte(if_byte),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_ack(dm_ack), .dm_rdata(dm_rdata),
    .op_valid(op_valid), .op_code(op_code), .op_done(op_done),
    .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c), .wptr(wptr), .iptr(iptr)
  );

  logic [7:0]  imem [256];
  logic [31:0] dmem [logic [31:0]];

  int checks = 0;
  int fails  = 0;
  int unsigned lfsr = 32'h1234_5678;
  int lat = 0;
  int op_cnt = 0;
  logic [31:0] op_seen = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return dmem.exists(a) ? dmem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_lat();
    lfsr = lfsr * 32'd1103515245 + 32'd12345;
    lat  = int'((lfsr >> 16) % 3);
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_a, m_b, m_c, m_w, m_i, m_or, m_addr, m_opc;
  int          m_ph;    // 0 fetch, 1 data, 2 operate
  logic [3:0]  m_kind;  // function code of pending data access

  task automatic m_push(input logic [31:0] v);
    m_c = m_b; m_b = m_a; m_a = v;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_c = 0; m_w = WP0; m_i = 0; m_or = 0;
      m_ph = 0; m_kind = 0; m_addr = 0; m_opc = 0;
    end else begin
      case (m_ph)
        0: if (if_ack) begin
          logic [7:0]  byt;
          logic [31:0] op;
          logic [31:0] nxt;
          byt = imem[m_i[7:0]];
          op  = m_or | {28'h0, byt[3:0]};
          nxt = m_i + 1;
          m_or = 0;
          case (byt[7:4])
            4'h2: m_or = op << 4;
            4'h6: m_or = (~op) << 4;
            4'h0: nxt = m_i + 1 + op;
            4'h1: m_push(m_w + op * 4);
            4'h4: m_push(op);
            4'h5: m_a = m_a + op * 4;
            4'hB: m_w = m_w + op * 4;
            4'hC: m_a = (m_a == op) ? 32'd1 : 32'd0;
            4'h7, 4'hD: begin m_ph = 1; m_kind = byt[7:4]; m_addr = m_w + op * 4; end
            4'h3, 4'hE: begin m_ph = 1; m_kind = byt[7:4]; m_addr = m_a + op * 4; end
            4'hF: begin m_ph = 2; m_opc = op; end
            default: ;
          endcase
          m_i = nxt;
        end
        1: if (dm_ack) begin
          case (m_kind)
            4'h7: m_push(rd(m_addr));
            4'h3: m_a = rd(m_addr);
            4'hD: begin m_a = m_b; m_b = m_c; end
            default: m_a = m_c;
          endcase
          m_ph = 0;
        end
        default: if (op_done) m_ph = 0;
      endcase
    end
  end

  task automatic compare();
    chk("R5 stack A", stk_a, m_a);
    chk("R6 stack B", stk_b, m_b);
    chk("R7 stack C", stk_c, m_c);
    chk("R8 workspace", wptr, m_w);
    chk("R9 iptr", iptr, m_i);
    chk("R13 one request", 32'($countones({if_req, dm_req, op_valid}) <= 1), 32'd1);
    chk("R10 if_req", 32'(if_req), 32'(m_ph == 0));
    if (m_ph == 0) chk("R10 if_addr", if_addr, m_i);
    chk("R11 dm_req", 32'(dm_req), 32'(m_ph == 1));
    if (m_ph == 1) begin
      chk("R11 dm_addr", dm_addr, m_addr);
      chk("R11 dm_we", 32'(dm_we), 32'(m_kind == 4'hD || m_kind == 4'hE));
      if (m_kind == 4'hD) chk("R6 store data", dm_wdata, m_a);
      if (m_kind == 4'hE) chk("R7 store data", dm_wdata, m_b);
    end
    chk("R12 op_valid", 32'(op_valid), 32'(m_ph == 2));
    if (m_ph == 2) chk("R12 op_code", op_code, m_opc);
  endtask

  // Responder and per-cycle comparison, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) compare();
      if_ack  = 1'b0;
      dm_ack  = 1'b0;
      op_done = 1'b0;
      if (rst_n) begin
        if (if_req || dm_req || op_valid) begin
          if (lat == 0) begin
            if (if_req) begin
              if_ack  = 1'b1;
              if_byte = imem[if_addr[7:0]];
            end else if (dm_req) begin
              dm_ack = 1'b1;
              if (dm_we) dmem[dm_addr] = dm_wdata;
              else dm_rdata = rd(dm_addr);
            end else begin
              op_done = 1'b1;
              op_seen = op_code;
              op_cnt++;
            end
            next_lat();
          end else begin
            lat--;
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic load_prog(input logic [7:0] prog[], input int base);
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    foreach (prog[i]) imem[base + i] = prog[i];
    dmem.delete();
    op_cnt = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] p1[], p2[], p3[];

    // Program 1: prefixes, constants, equality, reserved code
    p1 = '{8'h45, 8'h21, 8'h22, 8'h43, 8'h60, 8'h4F, 8'h61, 8'h40,
           8'h61, 8'hC0, 8'hC5, 8'h23, 8'h87, 8'h41, 8'h60, 8'h0E};
    load_prog(p1, 0);
    do_reset();
    // R1 reset state, sampled before the first active edge after reset
    chk("R1 A reset", stk_a, 32'h0);
    chk("R1 B reset", stk_b, 32'h0);
    chk("R1 C reset", stk_c, 32'h0);
    chk("R1 wptr reset", wptr, WP0);
    chk("R1 iptr reset", iptr, 32'h0);
    chk("R1 fetch request", 32'(if_req), 32'd1);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk("R2 reserved code clears operand", stk_a, 32'h1);
    chk("R8 eqc mismatch gives 0", stk_b, 32'h0);
    chk("R3 negative prefix value", stk_c, 32'hFFFF_FFFF);

    // Program 2: workspace, local and non-local memory traffic
    p2 = '{8'h47, 8'hD2, 8'h21, 8'h4A, 8'hD3, 8'h72, 8'h73, 8'h11,
           8'hE1, 8'h21, 8'h20, 8'h20, 8'h40, 8'h32, 8'h53, 8'hB4,
           8'h60, 8'hBF, 8'h70, 8'h60, 8'h0E};
    load_prog(p2, 0);
    do_reset();
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk("R5 load local result", stk_a, 32'h1A);
    chk("R7 ldnlp result", stk_b, 32'h26);
    chk("R7 stnl copies C", stk_c, 32'h7);
    chk("R8 ajw negative", wptr, 32'h100C);
    chk("R7 stnl overwrite word", rd(32'h1008), 32'h1A);
    chk("R6 stl word", rd(32'h100C), 32'h1A);

    // Program 3: jumps and operate handoff
    p3 = new[26];
    for (int i = 0; i < 26; i++) p3[i] = 8'h4F;
    p3[0] = 8'h49; p3[1] = 8'h02; p3[4] = 8'h21; p3[5] = 8'hF3;
    p3[6] = 8'h21; p3[7] = 8'h00; p3[24] = 8'h42;
    load_prog(p3, 0);
    p3 = new[2];
    imem[25] = 8'h60; imem[26] = 8'h0E;
    do_reset();
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk("R9 jump skipped bytes A", stk_a, 32'h2);
    chk("R9 jump skipped bytes B", stk_b, 32'h9);
    chk("R12 operate code", op_seen, 32'h13);
    chk("R12 single operate", 32'(op_cnt), 32'd1);
    chk("R9 halt loop", 32'(iptr == 32'd25 || iptr == 32'd26), 32'd1);
    chk("R4 operand cleared stack C", stk_c, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule